// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block sequences a set of shared pads that first serve as configuration inputs and then serve as clock outputs. After a cold start, the block waits for a power-good indication. It then runs a fixed sampling window, counted in reference-clock cycles. For the whole window every shared pad keeps its output driver disabled, so the external strap resistors, or the internal weak pulls, set the pad level.

On the final cycle of the window, the synchronized pad levels are captured into a one-shot configuration register. In the same step the output drivers of all shared pads are enabled, and a done flag goes high. The captured bits feed the frequency-select and mode logic elsewhere on the chip. They stay fixed until the next power cycle, which is modelled by the asynchronous reset.

The pad model has two inputs per pad. One is the sampled level. The other is a flag showing that nothing external drives the pad. When that flag is set, the internal pull decides the level: the highest frequency-select pad has a pull-down and reads 0, and every other pad has a pull-up and reads 1.

Top module: `strap_sample_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release until the window ends, sampled_done_o is 0 and cfg_o, fsel_o and mode_o are all 0.
- R2: While sampled_done_o is 0, every bit of pad_oe_o is 0, so all shared pads are tristated during idle and during the window.
- R3: sampled_done_o rises on the clock edge WINDOW_CYC+3 cycles after the first edge that sees pwr_good_i high: 2 cycles of synchronization, 1 start cycle, then WINDOW_CYC window cycles.
- R4: Each captured bit is 1 for a high pad level and 0 for a low one. Bits 0 to 3 are frequency-select bits 0 to 3, and bit 4 is the mode bit.
- R5: A pad with pad_float_i set is captured as its internal pull level: bit 3 reads 0, and bits 0, 1, 2 and 4 read 1.
- R6: The value captured is the one presented to the synchronizers on the last window cycle. A pad change made WINDOW_CYC cycles after the start edge (3 cycles before the end) is captured.
- R7: In the cycle where sampled_done_o rises, every bit of pad_oe_o is 1.
- R8: Once sampled_done_o is 1, it stays 1 and cfg_o stays unchanged, whatever pad_in_i, pad_float_i or pwr_good_i do. Only rst_ni clears them.
- R9: If pwr_good_i drops during the window, the window is abandoned and the pads stay tristated. A later rise of pwr_good_i starts a full new window.
- R10: fsel_o equals cfg_o[3:0], and mode_o equals cfg_o[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset (power removal) |
| pwr_good_i | input | 1 | Supply-good indication, asynchronous |
| pad_in_i | input | 5 | Sampled pad levels |
| pad_float_i | input | 5 | Pad has no external strap; internal pull applies |
| pad_oe_o | output | 5 | Per-pad output-driver enable |
| cfg_o | output | 5 | Captured configuration bits |
| fsel_o | output | 4 | Captured frequency-select bits |
| mode_o | output | 1 | Captured mode bit |
| sampled_done_o | output | 1 | Capture complete, outputs enabled |

## Verification
The bench counts edges from the rise of power-good to the rise of the done flag and checks the exact count. A timer that is off by one, or that skips the synchronizer latency, shows up as done or output enables moving one cycle early or late.

It changes the pads three cycles before the end of the window. A design that captures at the start of the window, or too early, keeps the stale value.

It toggles the pads and drops power-good after capture. A latch that can still be written, or an FSM that restarts, would then change cfg_o or tristate the pads again.

It aborts a window with a power-good glitch and expects a full new window afterwards. The pull defaults are checked with floating pads, and the pull-down bit is the one a uniform pull polarity gets wrong.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_DONE   = 2'd2
  } strap_state_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYC = 28636
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_sync_i,
  output logic capture_o,
  output logic done_o
);
  localparam int unsigned CW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

  strap_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (pg_sync_i) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!pg_sync_i) begin
          // supply lost mid-window: abandon and rearm
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          capture_o = 1'b1;
          state_d   = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned        N_PINS       = 5,
  parameter logic [N_PINS-1:0]  PULL_UP_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pad_in_i,
  input  logic [N_PINS-1:0] pad_float_i,
  input  logic              capture_i,
  output logic [N_PINS-1:0] cfg_o,
  output logic [N_PINS-1:0] oe_o
);
  logic [N_PINS-1:0] lvl, lvl_s;
  logic [N_PINS-1:0] cfg_q, oe_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pad
    // undriven pad settles to its internal pull
    assign lvl[i] = pad_float_i[i] ? PULL_UP_MASK[i] : pad_in_i[i];
  end

  strap_sync #(.WIDTH(N_PINS), .STAGES(2)) u_pad_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl),
    .q_o   (lvl_s)
  );

  // one-shot: only cold reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      oe_q  <= '0;
    end else if (capture_i) begin
      cfg_q <= lvl_s;
      oe_q  <= '1;
    end
  end

  assign cfg_o = cfg_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/strap_sample_ctrl.sv
module strap_sample_ctrl #(
  parameter int unsigned WINDOW_CYC   = 28636,
  parameter int unsigned N_FSEL       = 4,
  parameter logic [N_FSEL:0] PULL_UP_MASK = 5'b10111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [N_FSEL:0]   pad_in_i,
  input  logic [N_FSEL:0]   pad_float_i,
  output logic [N_FSEL:0]   pad_oe_o,
  output logic [N_FSEL:0]   cfg_o,
  output logic [N_FSEL-1:0] fsel_o,
  output logic              mode_o,
  output logic              sampled_done_o
);
  localparam int unsigned N_PINS = N_FSEL + 1;

  logic pg_s, capture, done;

  strap_sync #(.WIDTH(1), .STAGES(2)) u_pg_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_good_i),
    .q_o   (pg_s)
  );

  strap_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pg_sync_i(pg_s),
    .capture_o(capture),
    .done_o   (done)
  );

  strap_latch #(.N_PINS(N_PINS), .PULL_UP_MASK(PULL_UP_MASK)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pad_in_i   (pad_in_i),
    .pad_float_i(pad_float_i),
    .capture_i  (capture),
    .cfg_o      (cfg_o),
    .oe_o       (pad_oe_o)
  );

  assign fsel_o         = cfg_o[N_FSEL-1:0];
  assign mode_o         = cfg_o[N_FSEL];
  assign sampled_done_o = done;
endmodule

// File: rtl/strap_sample_ctrl_chk.sv
module strap_sample_ctrl_chk #(
  parameter int unsigned WINDOW_CYC = 28636,
  parameter int unsigned N_FSEL     = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pwr_good_i,
  input logic [N_FSEL:0] pad_oe_o,
  input logic [N_FSEL:0] cfg_o,
  input logic            sampled_done_o
);
  localparam int unsigned PW = $clog2(WINDOW_CYC + 8) + 1;
  localparam logic [PW-1:0] PMAX = '1;
  logic [PW-1:0] pg_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pg_cnt <= '0;
    else if (!pwr_good_i) pg_cnt <= '0;
    else if (pg_cnt != PMAX) pg_cnt <= pg_cnt + 1'b1;
  end

  assert_tristate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sampled_done_o |-> (pad_oe_o == '0));

  assert_cfg_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sampled_done_o |-> (cfg_o == '0));

  assert_oe_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sampled_done_o) |-> (&pad_oe_o));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_done_o |=> (sampled_done_o && $stable(cfg_o)));

  assert_window_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sampled_done_o) |-> (pg_cnt >= PW'(WINDOW_CYC)));
endmodule

bind strap_sample_ctrl strap_sample_ctrl_chk #(
  .WINDOW_CYC(WINDOW_CYC),
  .N_FSEL    (N_FSEL)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_good_i    (pwr_good_i),
  .pad_oe_o      (pad_oe_o),
  .cfg_o         (cfg_o),
  .sampled_done_o(sampled_done_o)
);

// File: tb/strap_sample_ctrl_bench.sv
module strap_sample_ctrl_bench;
  localparam int WIN = 16;
  localparam logic [4:0] PULL = 5'b10111;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b0;
  logic [4:0] pad_in_i = '0, pad_float_i = '0;
  logic [4:0] pad_oe_o, cfg_o;
  logic [3:0] fsel_o;
  logic mode_o, sampled_done_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strap_sample_ctrl #(.WINDOW_CYC(WIN)) u_strap_sample_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .pad_in_i(pad_in_i), .pad_float_i(pad_float_i),
    .pad_oe_o(pad_oe_o), .cfg_o(cfg_o), .fsel_o(fsel_o),
    .mode_o(mode_o), .sampled_done_o(sampled_done_o));

  function automatic logic [4:0] exp_cfg(logic [4:0] pins, logic [4:0] flt);
    for (int i = 0; i < 5; i++) exp_cfg[i] = flt[i] ? PULL[i] : pins[i];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cold_start();
    @(negedge clk);
    rst_ni = 1'b0; pwr_good_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(sampled_done_o == 0 && cfg_o == 0 && pad_oe_o == 0, "R1 reset",
        {sampled_done_o, cfg_o, pad_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // raise power-good at a negedge, step edges, optionally change pads at edge chg
  task automatic run_window(logic [4:0] p0, logic [4:0] f0, int chg,
                            logic [4:0] p1, logic [4:0] f1, logic [4:0] exp);
    bit seen_early = 0, seen_oe = 0;
    @(negedge clk);
    pad_in_i = p0; pad_float_i = f0; pwr_good_i = 1'b1;
    for (int k = 1; k <= WIN + 4; k++) begin
      @(posedge clk); #1;
      if (k < WIN + 3 && (sampled_done_o || pad_oe_o != 0)) seen_early = 1;
      if (k < WIN + 3 && cfg_o != 0) seen_early = 1;
      if (k == WIN + 3) begin
        chk(sampled_done_o == 1, "R3 done edge", sampled_done_o, 1);
        seen_oe = (pad_oe_o == 5'h1f);
        chk(seen_oe, "R7 oe with done", pad_oe_o, 5'h1f);
      end
      if (k == chg) begin pad_in_i = p1; pad_float_i = f1; end
    end
    chk(!seen_early, "R2 tristate in window", seen_early, 0);
    chk(cfg_o == exp, "R4 capture", cfg_o, exp);
    chk(fsel_o == exp[3:0] && mode_o == exp[4], "R10 split",
        {mode_o, fsel_o}, exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] p, f, held;
    void'($urandom(32'd4242));
    #2;
    chk(sampled_done_o == 0 && pad_oe_o == 0 && cfg_o == 0, "R1 initial",
        {sampled_done_o, pad_oe_o, cfg_o}, 0);
    cold_start();

    // directed: all driven high / low
    run_window(5'h1f, 5'h00, 0, 0, 0, 5'h1f);
    cold_start();
    run_window(5'h00, 5'h00, 0, 0, 0, 5'h00);

    // R5: all floating -> pull levels
    cold_start();
    run_window(5'h00, 5'h1f, 0, 0, 0, PULL);
    chk(cfg_o[3] == 0 && cfg_o[2:0] == 3'b111 && cfg_o[4], "R5 pulls", cfg_o, PULL);

    // R6: late change at edge WIN is still captured
    cold_start();
    run_window(5'h0a, 5'h00, WIN, 5'h15, 5'h00, 5'h15);
    chk(cfg_o == 5'h15, "R6 last-cycle capture", cfg_o, 5'h15);

    // R8: post-done activity ignored
    held = cfg_o;
    @(negedge clk);
    pad_in_i = ~pad_in_i; pad_float_i = 5'h1f; pwr_good_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(cfg_o == held && sampled_done_o && pad_oe_o == 5'h1f, "R8 sticky",
        {sampled_done_o, cfg_o}, {1'b1, held});
    pwr_good_i = 1'b1;
    repeat (WIN + 6) @(negedge clk);
    chk(cfg_o == held && sampled_done_o, "R8 no restart", cfg_o, held);

    // R9: power-good glitch mid-window
    cold_start();
    @(negedge clk);
    pad_in_i = 5'h03; pad_float_i = 0; pwr_good_i = 1'b1;
    repeat (WIN / 2) @(negedge clk);
    pwr_good_i = 1'b0;
    repeat (WIN + 4) @(negedge clk);
    chk(!sampled_done_o && pad_oe_o == 0 && cfg_o == 0, "R9 abort",
        {sampled_done_o, pad_oe_o}, 0);
    run_window(5'h0c, 5'h00, 0, 0, 0, 5'h0c);

    // random power cycles
    for (int n = 0; n < 10; n++) begin
      p = 5'($urandom); f = 5'($urandom);
      cold_start();
      run_window(p, f, 0, 0, 0, exp_cfg(p, f));
      chk(cfg_o == exp_cfg(p, f), "R5 random pulls", cfg_o, exp_cfg(p, f));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule